// File: doc/BRIEF.md
# Bank Interrupt Sense Unit

This unit watches the synchronised input pins of one GPIO bank, which is four ports of eight pins each, and turns selected pin activity into a single bank interrupt. Each port has a type register that gives every pin one of five sense modes: rising edge, falling edge, either edge, high level or low level. A pin takes part in sensing only while it is configured as an input. Detected events set sticky status bits. A per-port enable register masks those bits, and the bank interrupt is the OR of all enabled status bits across the four ports.

Software writes the registers through a simple write port. Each write selects a register kind (type, enable or clear) and a port. A clear write removes status bits by writing ones. When a new event and a clear hit the same bit in the same cycle, the event wins, so no event is lost. Priority encoding and vector generation belong to a later stage.

Top module: `bank_irq_sense`

## Requirements
- R1: After reset all status bits, all enable bits and `irqOut` are 0, and every type register is 0, which selects low-level sensing.
- R2: In the type register of a port, pin n uses three bits. Bit n is polarity (1 = high or rising). Bit 8+n selects edge sensing (1) or level sensing (0). Bit 16+n selects both edges when edge sensing is on. The codes per pin are: rising {16+n,8+n,n}=011, falling 010, both 110, high 001, low 000.
- R3: An edge is found by comparing the pin with its value one clock earlier. A qualifying edge on the input sets the status bit at the next clock edge, and an input that then holds steady raises no further event.
- R4: In level mode the status bit is set on every clock while the level is active. A clear written during that time has no effect, and the bit stays set after the level goes away until it is cleared.
- R5: A status bit, once set, holds its value until a clear removes it.
- R6: A clear write of value v to port p clears status bits p*8+n where bit n of v is 1. Bits of v that are 0 leave their status bits unchanged.
- R7: When an event and a clear for the same status bit occur in the same cycle, the bit ends up set.
- R8: `irqOut` is 1 exactly when some status bit and its enable bit are both 1, across all four ports.
- R9: A pin whose `pinIsInput` bit is 0 raises no event.
- R10: A write happens in the cycle `wrEn` is 1. `wrKind` 0 loads the type register from `wrData[23:0]`, 1 loads the enable register from `wrData[7:0]`, 2 is a clear using `wrData[7:0]`, and 3 does nothing. `wrPort` selects the port. Status bit p*8+n belongs to pin n of port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 32 | Synchronised pin levels, bit p*8+n for pin n of port p |
| pinIsInput | input | 32 | 1 where the pin is configured as a GPIO input |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | 0 type, 1 enable, 2 clear, 3 none |
| wrPort | input | 2 | Port addressed by the write |
| wrData | input | 24 | Write data |
| statusOut | output | 32 | Latched event status |
| irqOut | output | 1 | Bank interrupt |

## Verification
The assertions assume that `pinIn` is already synchronised and changes only between clock edges. They also assume that the pin levels seen during reset are the values against which the first edge is judged. The stimulus holds all pins low and all pins non-input through reset. It changes pins, input qualification and writes only at falling clock edges, one change per cycle, so each detected edge and each clear can be traced to a single cycle.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;
  localparam int NPORT = 4;
  localparam int NPIN = 8;
  localparam int NBIT = NPORT * NPIN;
  localparam int PORT_W = $clog2(NPORT);
  localparam int TYPE_W = 3 * NPIN;

  typedef enum logic [1:0] {
    KIND_TYPE = 2'd0,
    KIND_EN   = 2'd1,
    KIND_CLR  = 2'd2,
    KIND_NONE = 2'd3
  } wr_kind_e;

  typedef struct packed {
    logic [NPORT-1:0]  typeLd;
    logic [NPORT-1:0]  enLd;
    logic [NPORT-1:0]  clrLd;
    logic [TYPE_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
  import irq_sense_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [PORT_W-1:0] wrPort,
  input  logic [TYPE_W-1:0] wrData,
  output strobe_t           stb
);
  logic [NPORT-1:0] portHit;

  always_comb begin
    portHit = '0;
    portHit[wrPort] = wrEn;
  end

  always_comb begin
    stb.data   = wrData;
    stb.typeLd = (wr_kind_e'(wrKind) == KIND_TYPE) ? portHit : '0;
    stb.enLd   = (wr_kind_e'(wrKind) == KIND_EN)   ? portHit : '0;
    stb.clrLd  = (wr_kind_e'(wrKind) == KIND_CLR)  ? portHit : '0;
  end

  // R10: one write touches at most one register of one port
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.typeLd, stb.enLd, stb.clrLd}));
endmodule

// File: rtl/irq_sense_dp.sv
module irq_sense_dp
  import irq_sense_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NBIT-1:0] pinIn,
  input  logic [NBIT-1:0] pinIsInput,
  input  strobe_t         stb,
  output logic [NBIT-1:0] statusOut,
  output logic            irqOut
);
  logic [NBIT-1:0] prevIn;
  logic [NBIT-1:0] statusReg;
  logic [NBIT-1:0] enableAll;
  logic [NBIT-1:0] eventNow;
  logic [NBIT-1:0] clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= pinIn;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [TYPE_W-1:0] typeReg;
    logic [NPIN-1:0]   enReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        typeReg <= '0;
        enReg   <= '0;
      end else begin
        if (stb.typeLd[p]) typeReg <= stb.data;
        if (stb.enLd[p])   enReg   <= stb.data[NPIN-1:0];
      end
    end

    assign enableAll[p*NPIN +: NPIN] = enReg;
    assign clrMask[p*NPIN +: NPIN] = stb.clrLd[p] ? stb.data[NPIN-1:0] : '0;

    for (genvar n = 0; n < NPIN; n++) begin : g_pin
      localparam int B = p * NPIN + n;
      logic pol, edgeSel, dual, rise, fall, hit;

      assign pol     = typeReg[n];
      assign edgeSel = typeReg[NPIN + n];
      assign dual    = typeReg[2*NPIN + n];
      assign rise    = pinIn[B] & ~prevIn[B];
      assign fall    = ~pinIn[B] & prevIn[B];

      always_comb begin
        if (edgeSel) hit = dual ? (rise | fall) : (pol ? rise : fall);
        else         hit = pol ? pinIn[B] : ~pinIn[B];
      end

      assign eventNow[B] = pinIsInput[B] & hit;

      // R9: a non-input pin never sets its status bit
      p_noninput_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
        !pinIsInput[B] && !statusReg[B] |=> !statusReg[B]);
      // R7: an event sets status regardless of a simultaneous clear
      p_event_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
        eventNow[B] |=> statusReg[B]);
      // R5: set status with no clear stays set
      p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
        statusReg[B] && !clrMask[B] |=> statusReg[B]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (statusReg & ~clrMask) | eventNow;
  end

  assign statusOut = statusReg;
  assign irqOut    = |(statusReg & enableAll);

  // R8: no interrupt without a status bit
  p_quiet_without_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg == '0) |-> !irqOut);
endmodule

// File: rtl/bank_irq_sense.sv
module bank_irq_sense
  import irq_sense_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NBIT-1:0]   pinIn,
  input  logic [NBIT-1:0]   pinIsInput,
  input  logic              wrEn,
  input  logic [1:0]        wrKind,
  input  logic [PORT_W-1:0] wrPort,
  input  logic [TYPE_W-1:0] wrData,
  output logic [NBIT-1:0]   statusOut,
  output logic              irqOut
);
  strobe_t stb;

  irq_sense_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKind(wrKind),
    .wrPort(wrPort), .wrData(wrData), .stb(stb)
  );

  irq_sense_dp u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinIsInput(pinIsInput),
    .stb(stb), .statusOut(statusOut), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_bank_irq_sense.sv
module sim_bank_irq_sense;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = '0;
  logic [31:0] pinIsInput = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = 2'd3;
  logic [1:0]  wrPort = '0;
  logic [23:0] wrData = '0;
  logic [31:0] statusOut;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] expStat[$];
  logic        expIrq[$];
  string       expTag[$];

  always #2 clk = ~clk;

  bank_irq_sense u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinIsInput(pinIsInput),
    .wrEn(wrEn), .wrKind(wrKind), .wrPort(wrPort), .wrData(wrData),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  task automatic step(input logic [31:0] pins, input logic [31:0] isIn,
                      input logic we, input logic [1:0] kind, input logic [1:0] port,
                      input logic [23:0] data, input logic [31:0] eS, input logic eI,
                      input string tag);
    @(negedge clk);
    pinIn = pins; pinIsInput = isIn;
    wrEn = we; wrKind = kind; wrPort = port; wrData = data;
    expStat.push_back(eS); expIrq.push_back(eI); expTag.push_back(tag);
  endtask

  // monitor: compare each expectation just after the edge that produces it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expStat.size() > 0) begin
        logic [31:0] s;
        logic i;
        string t;
        s = expStat.pop_front(); i = expIrq.pop_front(); t = expTag.pop_front();
        total++;
        if (statusOut !== s || irqOut !== i) begin
          bad++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   t, statusOut, irqOut, s, i);
        end
      end
    end
  end

  initial begin
    #(4 * 5000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] IN0 = 32'h8000_00FF;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if (statusOut !== 32'h0 || irqOut !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: status=%h irq=%b expected status=0 irq=0", statusOut, irqOut);
    end
    @(negedge clk); rstN = 1'b1;
    // R2 R10: port 0 types: pin0 rising, pin1 falling, pin2 both, pin3 high, 4-7 low
    step(32'hF0, 32'h0, 1, 2'd0, 2'd0, 24'h040709, 32'h0, 0, "R10 type write");
    step(32'hF0, 32'h0, 1, 2'd1, 2'd0, 24'h0000FF, 32'h0, 0, "R10 enable write");
    // R1: port 3 pin 7 defaults to low level
    step(32'hF0, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0000, 0, "R1 default low level");
    step(32'hF1, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0001, 1, "R3 rising");
    step(32'hF1, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0001, 1, "R5 hold");
    step(32'hF1, IN0, 1, 2'd2, 2'd0, 24'h01, 32'h8000_0000, 0, "R6 clear");
    step(32'hF0, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0000, 0, "R3 fall ignored by rising pin");
    step(32'hF2, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0000, 0, "R3 rise ignored by falling pin");
    step(32'hF0, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0002, 1, "R3 falling");
    step(32'hF0, IN0, 1, 2'd2, 2'd0, 24'h02, 32'h8000_0000, 0, "R6 clear pin1");
    step(32'hF4, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0004, 1, "R2 both rise");
    step(32'hF0, IN0, 1, 2'd2, 2'd0, 24'h04, 32'h8000_0004, 1, "R7 event beats clear");
    step(32'hF0, IN0, 1, 2'd2, 2'd0, 24'h04, 32'h8000_0000, 0, "R6 clear pin2");
    step(32'hF8, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0008, 1, "R4 level high");
    step(32'hF8, IN0, 1, 2'd2, 2'd0, 24'h08, 32'h8000_0008, 1, "R4 clear while active");
    step(32'hF0, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0008, 1, "R4 latched after release");
    step(32'hF0, IN0, 1, 2'd2, 2'd0, 24'h08, 32'h8000_0000, 0, "R4 clear after release");
    step(32'hF1, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0001, 1, "R3 rising again");
    step(32'hF1, IN0, 1, 2'd2, 2'd0, 24'hFE, 32'h8000_0001, 1, "R6 zero bits ignored");
    step(32'hF0, IN0, 1, 2'd2, 2'd0, 24'h01, 32'h8000_0000, 0, "R6 clear pin0");
    step(32'hF1, 32'h8000_0000, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0000, 0, "R9 non-input pin");
    step(32'hF1, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h8000_0000, 0, "R3 steady input no event");
    step(32'hF1, IN0, 1, 2'd1, 2'd3, 24'h80, 32'h8000_0000, 1, "R8 port3 enable");
    step(32'h8000_00F1, IN0, 1, 2'd2, 2'd3, 24'h80, 32'h0, 0, "R8 port3 clear");
    step(32'h8000_00F1, IN0, 1, 2'd1, 2'd0, 24'h00, 32'h0, 0, "R8 disable port0");
    step(32'h8000_00F0, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h0, 0, "R3 fall no event");
    step(32'h8000_00F1, IN0, 0, 2'd3, 2'd0, 24'h0, 32'h1, 0, "R8 masked status");
    step(32'h8000_00F1, IN0, 1, 2'd3, 2'd0, 24'hFFFFFF, 32'h1, 0, "R10 kind 3 ignored");
    step(32'h8000_00F1, IN0, 1, 2'd1, 2'd0, 24'h00, 32'h1, 0, "R10 enable unchanged");
    @(negedge clk); wrEn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule